// File: doc/BRIEF.md
# Four-Output Bridge PWM Generator

This block produces a pulse-width-modulated waveform with 10-bit resolution and distributes it to four outputs, A to D, for a motor or H-bridge driver stage. The time base is an 8-bit coarse counter followed by a 2-bit fine prescale that counts every clock. Together they form a 10-bit count that is compared with a 10-bit duty value. The coarse part is compared with a period setting. When the period ends, the count restarts from zero, the modulated signal is set, and a new duty value is taken from the `duty` input. The signal is cleared when the count reaches that latched duty value.

A 2-bit mode input chooses how the modulated signal is steered:
- **Single:** the signal goes to any subset of the four outputs, chosen by a mask.
- **Half-bridge:** A carries the signal and B carries its complement.
- **Full-bridge:** two drive directions, described in R7 and R8.

Polarity is chosen separately for the A/C pair and the B/D pair. A per-output ownership flag shows which pins the block is currently driving. When `cfg_on` is taken low, the time base stops and every pin is released. When it is raised again, all outputs stay inactive until the first complete period has begun.

Top module: `bridge_pwm`

## Requirements
- R1: One PWM period lasts 4*(period+1) clocks. The coarse counter advances once every four clocks, and the count returns to zero after the clock in which it equals {period, 2'b11}.
- R2: During each period the modulated signal is active for exactly `duty` clocks, starting with the first clock of the period. A duty of 0 keeps it inactive. A duty of 4*(period+1) or more keeps it active.
- R3: `duty` is sampled only at a period boundary. A change made part-way through a period takes effect from the next period.
- R4: After `cfg_on` rises, every output stays at its inactive level for the first 4*period+3 clocks. The first active level can appear only in the first clock of the next period.
- R5: In mode 2'b00 (single), each output whose bit is set in `steer` (bit 0 = A, 1 = B, 2 = C, 3 = D) carries the modulated signal. `pwm_own` equals `steer`, and the other outputs stay inactive.
- R6: In mode 2'b10 (half-bridge), A carries the modulated signal and B its complement. `pwm_own` is 4'b0011, and C and D stay inactive.
- R7: In mode 2'b01 (forward full-bridge), A is held active, D is modulated, and B and C are inactive. `pwm_own` is 4'b1111.
- R8: In mode 2'b11 (reverse full-bridge), C is held active, B is modulated, and A and D are inactive. `pwm_own` is 4'b1111.
- R9: The inactive level of A and C is `pol_ac`, and the inactive level of B and D is `pol_bd`. A value of 0 means active-high and 1 means active-low. Released or unused outputs sit at their inactive level.
- R10: While `cfg_on` is low, `pwm_own` is 4'b0000 and all outputs are at their inactive level. The time base is reset to zero at the next clock.
- R11: During and right after reset, `pwm_own` is 0 and each output is at its inactive level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_on | input | 1 | Run enable; low releases all outputs |
| mode | input | 2 | Steering mode |
| period | input | 8 | Coarse period terminal count |
| duty | input | 10 | Duty value, taken at period boundaries |
| steer | input | 4 | Single-mode output mask, bit 0 = A |
| pol_ac | input | 1 | Inactive level of A and C |
| pol_bd | input | 1 | Inactive level of B and D |
| pwm_out | output | 4 | Outputs, bit 0 = A ... bit 3 = D |
| pwm_own | output | 4 | Per-output ownership flags |

## Verification
An error in the time base changes the length of the period. The next period then drifts against a count of 4*(period+1) samples, and the active count of the following window no longer matches. A wrong latched duty or a wrong set/reset flag shows within one period as a wrong number of active samples. A bad start flag is seen even sooner: an active level appears inside the 4*period+3 clocks after enable. Steering and polarity faults are seen in the very first period after start, because the bench counts active samples on all four pins.

// File: rtl/bridge_pwm_pkg.sv
`timescale 1ns/1ps
package bridge_pwm_pkg;
  typedef enum logic [1:0] {
    MODE_SINGLE = 2'b00,
    MODE_FWD    = 2'b01,
    MODE_HALF   = 2'b10,
    MODE_REV    = 2'b11
  } pwm_mode_e;
endpackage

// File: rtl/pwm_timebase.sv
`timescale 1ns/1ps
module pwm_timebase #(
  parameter int CNT_W  = 8,
  parameter int FINE_W = 2,
  localparam int TB_W  = CNT_W + FINE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic [CNT_W-1:0] period_i,
  output logic [TB_W-1:0]  tb_o,
  output logic             boundary_o
);
  logic [TB_W-1:0] tb_q, tb_d;

  assign boundary_o = run_i && (tb_q[TB_W-1:FINE_W] == period_i)
                      && (&tb_q[FINE_W-1:0]);

  always_comb begin
    if (!run_i)          tb_d = '0;
    else if (boundary_o) tb_d = '0;
    else                 tb_d = tb_q + TB_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tb_q <= '0;
    else        tb_q <= tb_d;
  end

  assign tb_o = tb_q;

  assert_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    boundary_o |=> (tb_q == '0));
  assert_advance_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && !boundary_o) |=> (tb_q == $past(tb_q) + TB_W'(1)));
  assert_stop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> (tb_q == '0));
endmodule

// File: rtl/pwm_modulator.sv
`timescale 1ns/1ps
module pwm_modulator #(
  parameter int TB_W = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run_i,
  input  logic            boundary_i,
  input  logic [TB_W-1:0] tb_i,
  input  logic [TB_W-1:0] duty_i,
  output logic            mod_o,
  output logic            started_o
);
  logic [TB_W-1:0] duty_q;
  logic            mod_q, mod_d, started_q, started_d, duty_ld;
  logic [TB_W-1:0] tb_inc;

  assign tb_inc  = tb_i + TB_W'(1);
  assign duty_ld = run_i && boundary_i;

  always_comb begin
    mod_d     = mod_q;
    started_d = started_q;
    if (!run_i) begin
      mod_d     = 1'b0;
      started_d = 1'b0;
    end else if (boundary_i) begin
      started_d = 1'b1;
      mod_d     = (duty_i != '0);
    end else if (mod_q && (tb_inc == duty_q)) begin
      mod_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mod_q     <= 1'b0;
      started_q <= 1'b0;
    end else begin
      mod_q     <= mod_d;
      started_q <= started_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       duty_q <= '0;
    else if (duty_ld) duty_q <= duty_i;
  end

  assign mod_o     = mod_q;
  assign started_o = started_q;

  assert_latch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    duty_ld |=> (duty_q == $past(duty_i)));
  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !duty_ld |=> $stable(duty_q));
  assert_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !started_q |-> !mod_q);
  assert_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (duty_ld && duty_i != '0) |=> mod_q);
  assert_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (duty_ld && duty_i == '0) |=> !mod_q);
endmodule

// File: rtl/pwm_steer.sv
`timescale 1ns/1ps
module pwm_steer
  import bridge_pwm_pkg::*;
#(
  parameter int N_OUT = 4
) (
  input  logic             en_i,
  input  logic             started_i,
  input  logic             mod_i,
  input  logic [1:0]       mode_i,
  input  logic [N_OUT-1:0] steer_i,
  input  logic [1:0]       pol_i,
  output logic [N_OUT-1:0] out_o,
  output logic [N_OUT-1:0] own_o
);
  logic [3:0] raw, mask;

  always_comb begin
    raw  = '0;
    mask = '0;
    unique case (pwm_mode_e'(mode_i))
      MODE_SINGLE: begin raw = {4{mod_i}};                  mask = steer_i[3:0]; end
      MODE_HALF:   begin raw = {2'b00, ~mod_i, mod_i};      mask = 4'b0011;      end
      MODE_FWD:    begin raw = {mod_i, 1'b0, 1'b0, 1'b1};   mask = 4'b1111;      end
      MODE_REV:    begin raw = {1'b0, 1'b1, mod_i, 1'b0};   mask = 4'b1111;      end
      default:     begin raw = '0;                          mask = '0;           end
    endcase
  end

  assign own_o = en_i ? mask[N_OUT-1:0] : '0;

  for (genvar i = 0; i < N_OUT; i++) begin : g_pin
    assign out_o[i] = (raw[i] & own_o[i] & started_i) ^ pol_i[i % 2];
  end
endmodule

// File: rtl/bridge_pwm.sv
`timescale 1ns/1ps
module bridge_pwm #(
  parameter int CNT_W  = 8,
  parameter int FINE_W = 2,
  localparam int TB_W  = CNT_W + FINE_W,
  localparam int N_OUT = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_on,
  input  logic [1:0]       mode,
  input  logic [CNT_W-1:0] period,
  input  logic [TB_W-1:0]  duty,
  input  logic [N_OUT-1:0] steer,
  input  logic             pol_ac,
  input  logic             pol_bd,
  output logic [N_OUT-1:0] pwm_out,
  output logic [N_OUT-1:0] pwm_own
);
  logic [TB_W-1:0] tb;
  logic            boundary, mod, started;
  logic [N_OUT-1:0] idle_lvl;

  pwm_timebase #(.CNT_W(CNT_W), .FINE_W(FINE_W)) u_tb (
    .clk(clk), .rst_n(rst_n), .run_i(cfg_on), .period_i(period),
    .tb_o(tb), .boundary_o(boundary));

  pwm_modulator #(.TB_W(TB_W)) u_mod (
    .clk(clk), .rst_n(rst_n), .run_i(cfg_on), .boundary_i(boundary),
    .tb_i(tb), .duty_i(duty), .mod_o(mod), .started_o(started));

  pwm_steer #(.N_OUT(N_OUT)) u_steer (
    .en_i(cfg_on), .started_i(started), .mod_i(mod), .mode_i(mode),
    .steer_i(steer), .pol_i({pol_bd, pol_ac}),
    .out_o(pwm_out), .own_o(pwm_own));

  assign idle_lvl = {pol_bd, pol_ac, pol_bd, pol_ac};

  assert_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_on |=> !started);
  assert_halfpair_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (started && cfg_on && mode == 2'b10) |->
      ((pwm_out[0] ^ pol_ac) != (pwm_out[1] ^ pol_bd)));
  assert_fwd_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (started && cfg_on && mode == 2'b01) |->
      ((pwm_out[0] ^ pol_ac) && (pwm_out[1] == pol_bd) && (pwm_out[2] == pol_ac)));
  assert_rev_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (started && cfg_on && mode == 2'b11) |->
      ((pwm_out[2] ^ pol_ac) && (pwm_out[0] == pol_ac) && (pwm_out[3] == pol_bd)));
  assert_unowned_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((pwm_out ^ idle_lvl) & ~pwm_own) == '0);
endmodule

// File: tb/sim_bridge_pwm.sv
`timescale 1ns/1ps
module sim_bridge_pwm;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_on = 1'b0;
  logic [1:0] mode = 2'b00;
  logic [7:0] period = 8'd3;
  logic [9:0] duty = '0;
  logic [3:0] steer = '0;
  logic       pol_ac = 1'b0, pol_bd = 1'b0;
  logic [3:0] pwm_out, pwm_own;

  int tests = 0, fails = 0;
  int cnt [4];
  int first [4];
  localparam int P = 3;
  localparam int N = 4 * (P + 1);

  always #4 clk = ~clk;

  bridge_pwm u0 (.clk(clk), .rst_n(rst_n), .cfg_on(cfg_on), .mode(mode),
    .period(period), .duty(duty), .steer(steer), .pol_ac(pol_ac),
    .pol_bd(pol_bd), .pwm_out(pwm_out), .pwm_own(pwm_own));

  function automatic logic [3:0] idle();
    return {pol_bd, pol_ac, pol_bd, pol_ac};
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Configure with run low, then enable and verify the idle gap (R4).
  task automatic start(input logic [1:0] m, input int d, input logic [3:0] s,
                       input logic pa, input logic pb);
    int bad = 0;
    @(negedge clk);
    cfg_on = 1'b0; mode = m; duty = 10'(d); steer = s; pol_ac = pa; pol_bd = pb;
    period = 8'(P);
    @(negedge clk);
    cfg_on = 1'b1;
    for (int i = 0; i < 4 * P + 3; i++) begin
      @(negedge clk);
      if (pwm_out != idle()) bad++;
    end
    check(bad == 0, "R4 idle gap after enable", bad, 0);
  endtask

  // Count active-level samples per pin over one period window.
  task automatic measure();
    for (int k = 0; k < 4; k++) begin cnt[k] = 0; first[k] = -1; end
    for (int i = 0; i < N; i++) begin
      @(negedge clk);
      for (int k = 0; k < 4; k++)
        if (pwm_out[k] != idle()[k]) begin
          cnt[k]++;
          if (first[k] < 0) first[k] = i;
        end
    end
  endtask

  task automatic chk4(input string req, input int a, input int b, input int c, input int d);
    check(cnt[0] == a, req, cnt[0], a);
    check(cnt[1] == b, req, cnt[1], b);
    check(cnt[2] == c, req, cnt[2], c);
    check(cnt[3] == d, req, cnt[3], d);
  endtask

  task automatic t_reset();
    check(pwm_own == 4'b0000, "R11 own after reset", pwm_own, 0);
    check(pwm_out == 4'b0000, "R11 out after reset", pwm_out, 0);
  endtask

  task automatic t_single();
    start(2'b00, 5, 4'b0101, 1'b0, 1'b0);
    measure();
    chk4("R5 R2 single mask 0101 duty 5", 5, 0, 5, 0);
    check(pwm_own == 4'b0101, "R5 own equals steer", pwm_own, 5);
    check(first[0] == 0, "R2 active from period start", first[0], 0);
    measure();
    check(first[0] == 0 && cnt[0] == 5, "R1 period length 4*(P+1)", first[0], 0);
  endtask

  task automatic t_half();
    start(2'b10, 6, 4'b0000, 1'b0, 1'b0);
    measure();
    chk4("R6 half-bridge complement", 6, N - 6, 0, 0);
    check(pwm_own == 4'b0011, "R6 own", pwm_own, 3);
  endtask

  task automatic t_fwd();
    start(2'b01, 7, 4'b0000, 1'b0, 1'b0);
    measure();
    chk4("R7 forward pattern", N, 0, 0, 7);
    check(pwm_own == 4'b1111, "R7 own", pwm_own, 15);
  endtask

  task automatic t_rev();
    start(2'b11, 7, 4'b0000, 1'b0, 1'b0);
    measure();
    chk4("R8 reverse pattern", 0, 7, N, 0);
    check(pwm_own == 4'b1111, "R8 own", pwm_own, 15);
  endtask

  task automatic t_pol();
    int hi0 = 0, hi2 = 0;
    start(2'b10, 6, 4'b0000, 1'b1, 1'b1);
    for (int i = 0; i < N; i++) begin
      @(negedge clk);
      if (pwm_out[0]) hi0++;
      if (pwm_out[2]) hi2++;
    end
    check(hi0 == N - 6, "R9 active-low A high count", hi0, N - 6);
    check(hi2 == N, "R9 unused C held at inactive level 1", hi2, N);
  endtask

  task automatic t_duty_edges();
    start(2'b00, 0, 4'b1111, 1'b0, 1'b0);
    measure();
    chk4("R2 duty 0 never active", 0, 0, 0, 0);
    start(2'b00, N, 4'b1111, 1'b0, 1'b0);
    measure();
    check(cnt[3] == N, "R2 duty equal full period", cnt[3], N);
    start(2'b00, N + 4, 4'b1111, 1'b0, 1'b0);
    measure();
    measure();
    check(cnt[1] == N, "R2 duty above period always active", cnt[1], N);
  endtask

  task automatic t_dbuf();
    int c = 0;
    start(2'b00, 4, 4'b0001, 1'b0, 1'b0);
    for (int i = 0; i < N; i++) begin
      @(negedge clk);
      if (pwm_out[0]) c++;
      if (i == 2) duty = 10'd9;
    end
    check(c == 4, "R3 mid-period duty change deferred", c, 4);
    measure();
    check(cnt[0] == 9, "R3 new duty in next period", cnt[0], 9);
  endtask

  task automatic t_release();
    start(2'b01, 7, 4'b0000, 1'b1, 1'b0);
    @(negedge clk);
    cfg_on = 1'b0;
    @(negedge clk);
    check(pwm_own == 4'b0000, "R10 own released", pwm_own, 0);
    check(pwm_out == idle(), "R10 outputs inactive", pwm_out, idle());
    start(2'b01, 7, 4'b0000, 1'b0, 1'b0);
    measure();
    check(cnt[3] == 7, "R10 restart after release", cnt[3], 7);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single();
    t_half();
    t_fwd();
    t_rev();
    t_pol();
    t_duty_edges();
    t_dbuf();
    t_release();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(8 * 100000);
    tests++;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule